// File: doc/BRIEF.md
# Synchronous Burst SRAM

A synthesizable model of a cache-style synchronous burst SRAM. The word is 18 bits wide and holds two byte lanes, each with a parity bit. The depth is set by the address width parameter. Every control input except output enable, the burst-order select and the sleep input is sampled on the rising clock edge. An access begins when either of two start strobes is seen low. One strobe is meant for a processor and the other for a cache controller. The first address comes from the address port. An internal two-bit beat counter then produces up to four addresses per burst. The counter moves on a low advance input and stays put when advance is high.

The burst order is chosen by a static select. In linear order the low two address bits count upward modulo four. In interleaved order they are the starting bits XOR the beat number. Writes may cover the whole word or single lanes. Three chip selects allow banks to be stacked in depth. An asynchronous output enable and a sleep input both silence the read port. Read data follows the current burst address without a pipeline register, and a valid flag marks it. After sleep is released, the start strobes are refused for two edges, and any strobe seen in that window is flagged.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset, rvalid_o, rdata_o and proto_err_o are all zero.
- R2: A processor strobe (cpu_strobe_n low) with sel0_n low, sel1 high and sel2_n low loads addr_i. In the following cycle rdata_o carries the stored word at that address and rvalid_o is high.
- R3: A controller strobe (ctl_strobe_n low, processor strobe not accepted) with all selects active is a write of wdata_i to addr_i on that edge when the write decode gives a write, and rvalid_o stays low. Otherwise it is a read, shown as in R2.
- R4: On an edge with an accepted processor strobe, the write inputs and advance_n are ignored. The edge is a read of the loaded address with beat 0.
- R5: While sel0_n is high, cpu_strobe_n is ignored and a running burst carries on unchanged.
- R6: A start strobe with any select inactive deselects the block. rvalid_o stays low, and advance has no effect, until the next accepted start.
- R7: With order_xor low, the low two address bits after k advances equal (start + k) mod 4. They return to the start after four advances.
- R8: With order_xor high, the low two address bits after k advances equal start XOR (k mod 4).
- R9: During a burst, an edge with advance_n high and no start keeps the current address.
- R10: Write decode. all_wr_n low writes both lanes. Otherwise, byte_wr_n low with wr_lo_n low writes lane A (bits 7:0 and parity bit 16), and with wr_hi_n low writes lane B (bits 15:8 and parity bit 17). Every other combination is a read.
- R11: On continuing edges of a burst, a write-decoded edge writes wdata_i at the address chosen on that edge. That is the next address if advancing and the held address if suspended.
- R12: While out_en_n is high, rdata_o and rvalid_o are zero. They return as soon as it falls.
- R13: While sleep_req is high, rdata_o and rvalid_o are zero, all synchronous inputs are ignored, and the contents are kept. For the first two edges after sleep_req falls, the state is frozen and start strobes are refused. proto_err_o is high in those cycles while either strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | External word address |
| cpu_strobe_n | input | 1 | Processor start strobe, active low |
| ctl_strobe_n | input | 1 | Controller start strobe, active low |
| advance_n | input | 1 | Burst advance, active low |
| all_wr_n | input | 1 | Whole-word write, active low |
| byte_wr_n | input | 1 | Lane write qualifier, active low |
| wr_lo_n | input | 1 | Lane A write, active low |
| wr_hi_n | input | 1 | Lane B write, active low |
| sel0_n | input | 1 | Chip select, active low, also gates the processor strobe |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep_req | input | 1 | Sleep request, level |
| order_xor | input | 1 | Burst order: 0 linear, 1 interleaved |
| wdata_i | input | 18 | Write data |
| rdata_o | output | 18 | Read data, zero when not valid |
| rvalid_o | output | 1 | Read data valid |
| proto_err_o | output | 1 | Strobe seen during the wake-up window |

## Verification
The bench sweeps every start offset, each of several upper address values, under both burst orders. It follows each burst through four advances and the wrap. A counter that used the wrong order or did not wrap would return the wrong stored word on some beat. Dedicated sequences target the following:
- a processor strobe that carries write inputs, which a faulty design would write;
- a processor strobe blocked by sel0_n, which a faulty design would take as a new start;
- suspended writes, which land on the held address rather than the next one;
- lane masks, where a wrong parity-bit position shows up on read-back;
- the two-edge wake window, where a design that accepted strobes early would load a new address and leave proto_err_o low.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

  localparam int WORD_W = 18;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_LOAD,
    EV_STEP,
    EV_HOLD,
    EV_DESEL
  } seq_evt_e;

  // low address bits of a burst beat
  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] beat,
                                           input logic       il);
    burst_low = il ? (start ^ beat) : (start + beat);
  endfunction

  // write decode: bit0 lane A, bit1 lane B
  function automatic logic [1:0] wr_lanes(input logic all_n, input logic byte_n,
                                          input logic lo_n, input logic hi_n);
    if (!all_n)       wr_lanes = 2'b11;
    else if (!byte_n) wr_lanes = {!hi_n, !lo_n};
    else              wr_lanes = 2'b00;
  endfunction

  // lane A: bits 7:0 + 16, lane B: bits 15:8 + 17
  function automatic logic [WORD_W-1:0] lane_bits(input logic [1:0] lanes);
    logic [WORD_W-1:0] m;
    m = '0;
    if (lanes[0]) begin
      m[7:0] = 8'hff;
      m[16]  = 1'b1;
    end
    if (lanes[1]) begin
      m[15:8] = 8'hff;
      m[17]   = 1'b1;
    end
    lane_bits = m;
  endfunction

endpackage

// File: rtl/bsram_wake.sv
module bsram_wake #(
  parameter int WAKE_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  output logic waking,
  output logic frozen
);
  localparam int CW = $clog2(WAKE_CYC + 1);

  logic [CW-1:0] wake_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    wake_cnt <= '0;
    else if (sleep_req)            wake_cnt <= CW'(WAKE_CYC);
    else if (wake_cnt != '0)       wake_cnt <= wake_cnt - 1'b1;
  end

  assign waking = (wake_cnt != '0) && !sleep_req;
  assign frozen = sleep_req || waking;

endmodule

// File: rtl/bsram_seq.sv
module bsram_seq
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frozen,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cpu_strobe_n,
  input  logic              ctl_strobe_n,
  input  logic              advance_n,
  input  logic              sel0_n,
  input  logic              sel1,
  input  logic              sel2_n,
  input  logic              wr_any,
  input  logic              order_xor,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              acc_wr,
  output logic              rd_q,
  output seq_evt_e          evt
);
  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        beat_q, beat_d;
  logic              act_q, act_d;
  logic              rd_d;
  logic              cpu_go, ctl_go, sel_ok, start;

  assign cpu_go = !cpu_strobe_n && !sel0_n;
  assign ctl_go = !ctl_strobe_n && !cpu_go;
  assign sel_ok = !sel0_n && sel1 && !sel2_n;
  assign start  = cpu_go || ctl_go;

  always_comb begin
    evt    = EV_NONE;
    base_d = base_q;
    beat_d = beat_q;
    act_d  = act_q;
    rd_d   = rd_q;
    acc_wr = 1'b0;
    if (!frozen) begin
      if (start) begin
        if (sel_ok) begin
          evt    = EV_LOAD;
          base_d = addr_i;
          beat_d = 2'd0;
          act_d  = 1'b1;
          acc_wr = ctl_go && wr_any;
          rd_d   = !(ctl_go && wr_any);
        end else begin
          evt   = EV_DESEL;
          act_d = 1'b0;
          rd_d  = 1'b0;
        end
      end else if (act_q) begin
        if (!advance_n) begin
          evt    = EV_STEP;
          beat_d = beat_q + 2'd1;
        end else begin
          evt = EV_HOLD;
        end
        acc_wr = wr_any;
        rd_d   = !wr_any;
      end else begin
        rd_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
      act_q  <= 1'b0;
      rd_q   <= 1'b0;
    end else begin
      base_q <= base_d;
      beat_q <= beat_d;
      act_q  <= act_d;
      rd_q   <= rd_d;
    end
  end

  assign cur_addr = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], beat_q, order_xor)};
  assign acc_addr = {base_d[ADDR_W-1:2], burst_low(base_d[1:0], beat_d, order_xor)};

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    evt == EV_STEP |=> beat_q == $past(beat_q) + 2'd1); // R7
  AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    evt == EV_HOLD |=> $stable(cur_addr)); // R9
  AST_CPU_START_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt == EV_LOAD && !cpu_strobe_n && !sel0_n) |-> !acc_wr); // R4
  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    evt == EV_DESEL |=> !rd_q); // R6

endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wmask,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= (mem[waddr] & ~wmask) | (wdata & wmask);
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import bsram_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int WAKE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cpu_strobe_n,
  input  logic              ctl_strobe_n,
  input  logic              advance_n,
  input  logic              all_wr_n,
  input  logic              byte_wr_n,
  input  logic              wr_lo_n,
  input  logic              wr_hi_n,
  input  logic              sel0_n,
  input  logic              sel1,
  input  logic              sel2_n,
  input  logic              out_en_n,
  input  logic              sleep_req,
  input  logic              order_xor,
  input  logic [17:0]       wdata_i,
  output logic [17:0]       rdata_o,
  output logic              rvalid_o,
  output logic              proto_err_o
);
  logic [1:0]        lanes;
  logic              wr_any;
  logic              waking, frozen;
  logic [ADDR_W-1:0] cur_addr, acc_addr;
  logic              acc_wr, rd_q;
  seq_evt_e          evt;
  logic [17:0]       arr_rdata;

  assign lanes  = wr_lanes(all_wr_n, byte_wr_n, wr_lo_n, wr_hi_n);
  assign wr_any = |lanes;

  bsram_wake #(.WAKE_CYC(WAKE_CYC)) wake_i (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
    .waking(waking), .frozen(frozen)
  );

  bsram_seq #(.ADDR_W(ADDR_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .frozen(frozen), .addr_i(addr_i),
    .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n),
    .advance_n(advance_n), .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
    .wr_any(wr_any), .order_xor(order_xor), .cur_addr(cur_addr),
    .acc_addr(acc_addr), .acc_wr(acc_wr), .rd_q(rd_q), .evt(evt)
  );

  bsram_array #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) array_i (
    .clk(clk), .we(acc_wr), .waddr(acc_addr), .wmask(lane_bits(lanes)),
    .wdata(wdata_i), .raddr(cur_addr), .rdata(arr_rdata)
  );

  assign rvalid_o    = rd_q && !out_en_n && !sleep_req;
  assign rdata_o     = rvalid_o ? arr_rdata : '0;
  assign proto_err_o = waking && (!cpu_strobe_n || !ctl_strobe_n);

  AST_WAKE_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    waking |-> evt != EV_LOAD); // R13
  AST_SLEEP_KEEPS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frozen) |-> $stable(cur_addr)); // R13
  AST_NO_WRITE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |-> !acc_wr); // R13

endmodule

// File: tb/sync_burst_sram_tb_top.sv
module sync_burst_sram_tb_top;
  localparam int AW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr;
  logic cpu_n, ctl_n, adv_n, all_n, byte_n, lo_n, hi_n;
  logic s0_n, s1, s2_n, oe_n, slp, il;
  logic [17:0] wdata, rdata;
  logic rvalid, perr;
  logic [17:0] exp_mem [64];
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sync_burst_sram #(.ADDR_W(AW), .WAKE_CYC(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .cpu_strobe_n(cpu_n),
    .ctl_strobe_n(ctl_n), .advance_n(adv_n), .all_wr_n(all_n),
    .byte_wr_n(byte_n), .wr_lo_n(lo_n), .wr_hi_n(hi_n), .sel0_n(s0_n),
    .sel1(s1), .sel2_n(s2_n), .out_en_n(oe_n), .sleep_req(slp),
    .order_xor(il), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .proto_err_o(perr)
  );

  function automatic logic [17:0] pat(input int a);
    return 18'((a * 2731 + 413) ^ (a << 11));
  endfunction

  function automatic int beat_addr(input int a, input int k, input logic x);
    int lo;
    lo = x ? ((a % 4) ^ (k % 4)) : (((a % 4) + k) % 4);
    return (a / 4) * 4 + lo;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [17:0] act,
                     input logic [17:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    cpu_n = 1; ctl_n = 1; adv_n = 1; all_n = 1; byte_n = 1; lo_n = 1; hi_n = 1;
    s0_n = 0; s1 = 1; s2_n = 0;
  endtask

  task automatic cpu_read(input int a);
    idle(); cpu_n = 0; addr = AW'(a); tick(); idle();
  endtask

  task automatic rd_chk(input int a, input string req);
    chk(rvalid === 1'b1 && rdata === exp_mem[a], req, rdata, exp_mem[a]);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%h expected=%h", 18'h0, 18'h1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(); oe_n = 0; slp = 0; il = 0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1
    chk(rvalid === 0 && rdata === 0 && perr === 0, "R1", rdata, 18'h0);

    // R3 fill with controller-strobe full writes
    for (int a = 0; a < 64; a++) begin
      idle(); ctl_n = 0; addr = AW'(a); all_n = 0; wdata = pat(a);
      tick();
      exp_mem[a] = pat(a);
      chk(rvalid === 0, "R3 write no valid", {17'h0, rvalid}, 18'h0);
    end
    idle();

    // R2 R4 R7 R8 sweep
    for (int x = 0; x < 2; x++) begin
      il = x[0];
      for (int h = 0; h < 16; h++) begin
        for (int s = 0; s < 4; s++) begin
          int a;
          a = h * 4 + s;
          idle(); cpu_n = 0; addr = AW'(a); all_n = 0; adv_n = 0; wdata = ~pat(a);
          tick();
          rd_chk(a, "R2 R4 start read");
          for (int k = 1; k <= 4; k++) begin
            idle(); adv_n = 0; tick();
            rd_chk(beat_addr(a, k, il), il ? "R8 interleaved" : "R7 linear");
          end
        end
      end
    end
    il = 0;

    // R9 suspend
    cpu_read(9); idle(); adv_n = 0; tick(); idle();
    rd_chk(10, "R7 step");
    tick(); rd_chk(10, "R9 hold");
    tick(); rd_chk(10, "R9 hold");

    // R5 blocked processor strobe
    idle(); s0_n = 1; cpu_n = 0; addr = AW'(40); tick(); idle();
    rd_chk(10, "R5 blocked");
    adv_n = 0; tick(); idle();
    rd_chk(11, "R5 burst continues");

    // R6 deselect
    idle(); ctl_n = 0; s1 = 0; addr = AW'(20); tick(); idle();
    chk(rvalid === 0, "R6 desel ctl", {17'h0, rvalid}, 18'h0);
    adv_n = 0; tick(); idle();
    chk(rvalid === 0, "R6 advance ignored", {17'h0, rvalid}, 18'h0);
    cpu_n = 0; s2_n = 1; addr = AW'(21); tick(); idle();
    chk(rvalid === 0, "R6 desel cpu", {17'h0, rvalid}, 18'h0);

    // R10 lane writes at 33
    idle(); ctl_n = 0; addr = AW'(33); byte_n = 0; lo_n = 0; wdata = 18'h3ffff;
    tick();
    exp_mem[33] = exp_mem[33] | 18'h100ff;
    cpu_read(33); rd_chk(33, "R10 lane A");
    idle(); ctl_n = 0; addr = AW'(33); byte_n = 0; hi_n = 0; wdata = 18'h0;
    tick();
    exp_mem[33] = exp_mem[33] & ~18'h2ff00;
    cpu_read(33); rd_chk(33, "R10 lane B");
    idle(); ctl_n = 0; addr = AW'(33); byte_n = 0; wdata = 18'h15a5a;
    tick(); idle();
    rd_chk(33, "R10 R3 byte qualifier alone reads");
    idle(); ctl_n = 0; addr = AW'(33); all_n = 0; byte_n = 0; lo_n = 0; wdata = 18'h2c3d4;
    tick();
    exp_mem[33] = 18'h2c3d4;
    cpu_read(33); rd_chk(33, "R10 whole word overrides");

    // R11 continuing writes
    idle(); ctl_n = 0; addr = AW'(44); all_n = 0; wdata = 18'h11111; tick();
    exp_mem[44] = 18'h11111;
    idle(); adv_n = 0; all_n = 0; wdata = 18'h22222; tick();
    exp_mem[45] = 18'h22222;
    idle(); all_n = 0; wdata = 18'h33333; tick();
    exp_mem[45] = 18'h33333;
    idle(); adv_n = 0; all_n = 0; wdata = 18'h04444; tick();
    exp_mem[46] = 18'h04444;
    idle();
    cpu_read(44); rd_chk(44, "R11 first");
    cpu_read(45); rd_chk(45, "R11 suspended write");
    cpu_read(46); rd_chk(46, "R11 advanced write");
    cpu_read(47); rd_chk(47, "R11 untouched");

    // R12 output enable
    cpu_read(50);
    oe_n = 1; #1;
    chk(rvalid === 0 && rdata === 0, "R12 disabled", rdata, 18'h0);
    oe_n = 0; #1;
    rd_chk(50, "R12 restored");

    // R13 sleep and wake
    cpu_read(51);
    slp = 1; #1;
    chk(rvalid === 0 && rdata === 0, "R13 sleep dark", rdata, 18'h0);
    ctl_n = 0; all_n = 0; addr = AW'(52); wdata = 18'h0;
    repeat (3) tick();
    chk(rdata === 0 && perr === 0, "R13 asleep", rdata, 18'h0);
    idle(); slp = 0; cpu_n = 0; addr = AW'(53); #1;
    chk(perr === 1, "R13 wake err 1", {17'h0, perr}, 18'h1);
    tick();
    chk(perr === 1, "R13 wake err 2", {17'h0, perr}, 18'h1);
    rd_chk(51, "R13 refused 1");
    tick();
    chk(perr === 0, "R13 window over", {17'h0, perr}, 18'h0);
    rd_chk(51, "R13 refused 2");
    tick(); idle();
    rd_chk(53, "R13 accepted");
    cpu_read(52); rd_chk(52, "R13 contents kept");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule